// File: doc/BRIEF.md
# Byte-Serial 24-Bit Up/Down Counter Channel

This block is one axis of a multi-axis position counter. It takes count-up and count-down pulses from a separate input decoder and keeps a 24-bit count. A host reaches it through two byte-wide ports that share one write data bus. The data port writes a 24-bit preset register and reads a 24-bit snapshot register, one byte per access. A single internal byte pointer picks the byte for both reads and writes. The control port takes command bytes. Reading the status byte shows the wrap flags, an input-noise error flag and the direction of the last count.

The only way to load an arbitrary value into the counter is to write it into the preset and then transfer it. The host never reads the live counter. It first copies it into the snapshot register, so a reading cannot tear while pulses keep arriving. Software can keep the sticky borrow and carry flags and combine them with the 24-bit value to get one extra bit of range. Four counting modes use the preset as their limit. An index pulse can also reload the counter from the preset.

Top module: `ctr24_channel`

## Requirements
- R1: After reset the preset, counter and snapshot register are zero. The byte pointer is at byte 0 and the status byte reads 0x00. Counting is disabled, the index function is off and the mode is normal.
- R2: A control byte with bits 7:5 = 000 and bit 0 set returns the byte pointer to byte 0. Each data-port write stores the byte into the preset byte at the pointer, least significant byte first, and advances the pointer. Data-port reads advance the same pointer. After byte 2 the pointer wraps to byte 0.
- R3: A command byte (bits 7:5 = 000) with bit 3 set copies the preset into the counter.
- R4: A command byte with bit 4 set copies the counter value from before that edge into the snapshot register. Byte 0x11 also resets the pointer, so the next three reads return the snapshot least significant byte first. The snapshot keeps its value until the next copy.
- R5: In a command byte, bits 2:1 are one field. 01 clears the counter, 10 clears borrow and carry, and 11 clears the error flag. Command bits may be combined in one byte. When bit 3 and field 01 appear together, the preset transfer wins.
- R6: A control byte with bits 7:5 = 010 loads the I/O settings: bit 0 enables the count pulses and bit 1 is an active-low enable for loading the preset on index. While bit 0 is 0, count pulses are ignored. An up and a down pulse in the same cycle leave the counter unchanged.
- R7: Status bit 0 is borrow, bit 1 is carry, bit 4 is the noise error and bit 5 is direction (1 = last count was up); the other bits read 0. In normal mode (mode bits 2:1 = 00) counting up from 0xFFFFFF gives 0 and sets carry, and counting down from 0 gives 0xFFFFFF and sets borrow. Both flags stay set until cleared.
- R8: A control byte with bits 7:5 = 001 loads the mode. Bits 2:1 = 01 selects range-limit: counting up while the count equals the preset holds the count and sets carry, and counting down at 0 holds 0 and sets borrow. Mode bit 0 has no effect.
- R9: Mode bits 2:1 = 10 selects non-recycle. The counter wraps as in normal mode and sets the flag, then ignores count pulses until a preset transfer, a counter clear or an index load.
- R10: Mode bits 2:1 = 11 selects modulo-N. Counting up while the count equals the preset gives 0 and sets carry. Counting down at 0 loads the preset and sets borrow.
- R11: A control byte with bits 7:5 = 011 and bit 0 set enables the index function. With it enabled and I/O bit 1 at 0, an index pulse loads the preset into the counter. With I/O bit 1 at 1, index pulses are ignored.
- R12: A noise pulse input sets the error flag. It stays set until a clear-error command.
- R13: In a cycle with a control-port write, count pulses and index pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control-port write strobe; wrData holds the control byte |
| dataWe | input | 1 | Data-port write strobe; wrData goes to the preset byte at the pointer |
| dataRe | input | 1 | Data-port read strobe; advances the byte pointer |
| wrData | input | 8 | Write data shared by both ports |
| rdData | output | 8 | Snapshot byte at the current pointer |
| statusByte | output | 8 | Borrow, carry, error and direction flags |
| cntUp | input | 1 | Count-up pulse, one cycle per count |
| cntDn | input | 1 | Count-down pulse, one cycle per count |
| indexIn | input | 1 | Qualified index pulse |
| noiseIn | input | 1 | Excessive-noise pulse from the input stage |

## Verification
Only two things reach the ports: the snapshot register, through the byte pointer, and the status byte. A corrupt counter or preset therefore stays hidden until the next copy command, and then shows in full on the three following data-port reads. A wrong byte pointer shows at the next read as rotated bytes. A flag or halt state that is set or cleared wrongly shows in the status byte on the cycle after the edge that caused it. It can also show as a frozen or wrongly wrapped count at the next snapshot. The bench therefore follows every stimulus with a snapshot and three reads, or with a status compare on the next cycle.

// File: rtl/ctr24_pkg.sv
package ctr24_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL    = 2'b00,
    MODE_RANGE     = 2'b01,
    MODE_NORECYCLE = 2'b10,
    MODE_MODULO    = 2'b11
  } countMode_e;

  typedef enum logic [2:0] {
    TGT_CMD   = 3'b000,
    TGT_MODE  = 3'b001,
    TGT_IO    = 3'b010,
    TGT_INDEX = 3'b011
  } ctrlTarget_e;

  // Strobes from the control decode to the datapath, valid for one cycle
  typedef struct packed {
    logic hold;      // control write this cycle: ignore count and index pulses
    logic wrPreset;  // store wrData into the preset byte at the pointer
    logic loadCnt;   // preset -> counter
    logic clrCnt;    // counter -> 0
    logic clrFlags;  // borrow and carry -> 0
    logic clrErr;    // error -> 0
    logic latchCnt;  // counter -> snapshot
  } dpStrobe_t;

  typedef struct packed {
    logic       cntEnable;
    logic       idxPresetEn;
    countMode_e mode;
  } dpConfig_t;

  localparam int ST_BORROW = 0;
  localparam int ST_CARRY  = 1;
  localparam int ST_ERROR  = 4;
  localparam int ST_DIRUP  = 5;

endpackage

// File: rtl/ctr24_ctrl.sv
module ctr24_ctrl
  import ctr24_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int PTR_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic             dataWe,
  input  logic             dataRe,
  input  logic [7:0]       wrData,
  output dpStrobe_t        strobe,
  output dpConfig_t        cfg,
  output logic [PTR_W-1:0] bytePtr
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(CNT_BYTES - 1);

  ctrlTarget_e target;
  logic [4:0]  payload;
  logic        isCmd;
  logic        ptrReset;

  logic       ioEnableQ;
  logic       ioPresetNQ;
  logic       idxEnableQ;
  countMode_e modeQ;

  // Payload bits this block gives no function: mode bits 4:3 and 0,
  // I/O bits 4:2, index bits 4:1
  logic unusedPayload;

  assign target   = ctrlTarget_e'(wrData[7:5]);
  assign payload  = wrData[4:0];
  assign isCmd    = ctrlWe && (target == TGT_CMD);
  assign ptrReset = isCmd && payload[0];
  assign unusedPayload = ^{payload[4:3], payload[0]};

  always_comb begin
    strobe          = '0;
    strobe.hold     = ctrlWe;
    strobe.wrPreset = dataWe;
    strobe.loadCnt  = isCmd && payload[3];
    strobe.clrCnt   = isCmd && (payload[2:1] == 2'b01) && !payload[3];
    strobe.clrFlags = isCmd && (payload[2:1] == 2'b10);
    strobe.clrErr   = isCmd && (payload[2:1] == 2'b11);
    strobe.latchCnt = isCmd && payload[4];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioEnableQ  <= 1'b0;
      ioPresetNQ <= 1'b0;
      idxEnableQ <= 1'b0;
      modeQ      <= MODE_NORMAL;
    end else if (ctrlWe) begin
      case (target)
        TGT_MODE:  modeQ <= countMode_e'(payload[2:1]);
        TGT_IO: begin
          ioEnableQ  <= payload[0];
          ioPresetNQ <= payload[1];
        end
        TGT_INDEX: idxEnableQ <= payload[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytePtr <= '0;
    end else if (ptrReset) begin
      bytePtr <= '0;
    end else if (dataWe || dataRe) begin
      bytePtr <= (bytePtr == LAST_PTR) ? '0 : bytePtr + PTR_W'(1);
    end
  end

  assign cfg.cntEnable   = ioEnableQ;
  assign cfg.idxPresetEn = idxEnableQ && !ioPresetNQ;
  assign cfg.mode        = modeQ;

  AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rstN)
    ptrReset |=> bytePtr == '0);  // R2

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe || dataRe) && !ctrlWe && bytePtr == LAST_PTR |=> bytePtr == '0);  // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe || dataRe) && !ctrlWe && bytePtr != LAST_PTR
      |=> bytePtr == $past(bytePtr) + PTR_W'(1));  // R2

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWe |=> $stable(cfg));  // R6

endmodule

// File: rtl/ctr24_dpath.sv
module ctr24_dpath
  import ctr24_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int PTR_W     = 2,
  parameter int CNT_W     = 8 * CNT_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  dpConfig_t        cfg,
  input  logic [PTR_W-1:0] bytePtr,
  input  logic [7:0]       wrData,
  input  logic             cntUp,
  input  logic             cntDn,
  input  logic             indexIn,
  input  logic             noiseIn,
  output logic [7:0]       rdData,
  output logic [7:0]       statusByte
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] presetR;
  logic [CNT_W-1:0] cntR;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] snapR;
  logic [CNT_W-1:0] upLimit;
  logic borrowR, carryR, errR, dirUpR, haltedR;
  logic idxLoad, upEv, dnEv;
  logic setCarry, setBorrow, haltSet;

  // Preset register, one lane per byte
  for (genvar g = 0; g < CNT_BYTES; g++) begin : gLane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (strobe.wrPreset && bytePtr == PTR_W'(g)) begin
        laneQ <= wrData;
      end
    end
    assign presetR[g*8 +: 8] = laneQ;
  end

  assign idxLoad = indexIn && cfg.idxPresetEn && !strobe.hold;
  assign upEv = cntUp && !cntDn && cfg.cntEnable && !strobe.hold && !haltedR && !idxLoad;
  assign dnEv = cntDn && !cntUp && cfg.cntEnable && !strobe.hold && !haltedR && !idxLoad;
  assign upLimit = (cfg.mode == MODE_RANGE || cfg.mode == MODE_MODULO) ? presetR : CNT_MAX;

  always_comb begin
    cntNext   = cntR;
    setCarry  = 1'b0;
    setBorrow = 1'b0;
    haltSet   = 1'b0;
    if (upEv) begin
      if (cntR == upLimit) begin
        setCarry = 1'b1;
        case (cfg.mode)
          MODE_RANGE:     cntNext = cntR;
          MODE_NORECYCLE: begin cntNext = '0; haltSet = 1'b1; end
          default:        cntNext = '0;
        endcase
      end else begin
        cntNext = cntR + CNT_W'(1);
      end
    end else if (dnEv) begin
      if (cntR == '0) begin
        setBorrow = 1'b1;
        case (cfg.mode)
          MODE_RANGE:     cntNext = cntR;
          MODE_MODULO:    cntNext = presetR;
          MODE_NORECYCLE: begin cntNext = CNT_MAX; haltSet = 1'b1; end
          default:        cntNext = CNT_MAX;
        endcase
      end else begin
        cntNext = cntR - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntR    <= '0;
      haltedR <= 1'b0;
    end else if (strobe.loadCnt || idxLoad) begin
      cntR    <= presetR;
      haltedR <= 1'b0;
    end else if (strobe.clrCnt) begin
      cntR    <= '0;
      haltedR <= 1'b0;
    end else begin
      cntR    <= cntNext;
      haltedR <= haltedR || haltSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapR <= '0;
    end else if (strobe.latchCnt) begin
      snapR <= cntR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      borrowR <= 1'b0;
      carryR  <= 1'b0;
      errR    <= 1'b0;
      dirUpR  <= 1'b0;
    end else begin
      borrowR <= strobe.clrFlags ? 1'b0 : (borrowR || setBorrow);
      carryR  <= strobe.clrFlags ? 1'b0 : (carryR || setCarry);
      errR    <= (errR && !strobe.clrErr) || noiseIn;
      if (upEv)      dirUpR <= 1'b1;
      else if (dnEv) dirUpR <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (bytePtr == PTR_W'(i)) rdData = snapR[i*8 +: 8];
    end
  end

  always_comb begin
    statusByte            = '0;
    statusByte[ST_BORROW] = borrowR;
    statusByte[ST_CARRY]  = carryR;
    statusByte[ST_ERROR]  = errR;
    statusByte[ST_DIRUP]  = dirUpR;
  end

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> cntR == $past(presetR));  // R3

  AST_NORMAL_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    upEv && cfg.mode == MODE_NORMAL && cntR == CNT_MAX |=> cntR == '0 && carryR);  // R7

  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    upEv && cfg.mode == MODE_RANGE && cntR == presetR |=> $stable(cntR) && carryR);  // R8

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    haltedR && !strobe.loadCnt && !strobe.clrCnt && !idxLoad |=> $stable(cntR));  // R9

  AST_MODULO_BORROW: assert property (@(posedge clk) disable iff (!rstN)
    dnEv && cfg.mode == MODE_MODULO && cntR == '0 |=> cntR == $past(presetR) && borrowR);  // R10

  AST_DISABLED_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.cntEnable && !strobe.loadCnt && !strobe.clrCnt && !idxLoad |=> $stable(cntR));  // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errR && !strobe.clrErr |=> errR);  // R12

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold && !strobe.loadCnt && !strobe.clrCnt |=> $stable(cntR));  // R13

endmodule

// File: rtl/ctr24_channel.sv
module ctr24_channel
  import ctr24_pkg::*;
#(
  parameter int CNT_BYTES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic       dataWe,
  input  logic       dataRe,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [7:0] statusByte,
  input  logic       cntUp,
  input  logic       cntDn,
  input  logic       indexIn,
  input  logic       noiseIn
);

  localparam int PTR_W = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;
  localparam int CNT_W = 8 * CNT_BYTES;

  dpStrobe_t        strobe;
  dpConfig_t        cfg;
  logic [PTR_W-1:0] bytePtr;

  ctr24_ctrl #(.CNT_BYTES(CNT_BYTES), .PTR_W(PTR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlWe  (ctrlWe),
    .dataWe  (dataWe),
    .dataRe  (dataRe),
    .wrData  (wrData),
    .strobe  (strobe),
    .cfg     (cfg),
    .bytePtr (bytePtr)
  );

  ctr24_dpath #(.CNT_BYTES(CNT_BYTES), .PTR_W(PTR_W), .CNT_W(CNT_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfg        (cfg),
    .bytePtr    (bytePtr),
    .wrData     (wrData),
    .cntUp      (cntUp),
    .cntDn      (cntDn),
    .indexIn    (indexIn),
    .noiseIn    (noiseIn),
    .rdData     (rdData),
    .statusByte (statusByte)
  );

endmodule

// File: tb/tb_ctr24_channel.sv
`timescale 1ns/1ps
module tb_ctr24_channel;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0, dataWe = 1'b0, dataRe = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, statusByte;
  logic cntUp = 1'b0, cntDn = 1'b0, indexIn = 1'b0, noiseIn = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctr24_channel dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .dataWe(dataWe), .dataRe(dataRe),
    .wrData(wrData), .rdData(rdData), .statusByte(statusByte),
    .cntUp(cntUp), .cntDn(cntDn), .indexIn(indexIn), .noiseIn(noiseIn)
  );

  // Vector: {op[3:0], req[3:0], data[7:0], expected[7:0]}
  // op 1 ctrl write, 2 data write, 3 read+compare, 4 status compare,
  //    5 up pulse, 6 down pulse, 7 noise pulse
  localparam int NV = 48;
  localparam logic [23:0] VEC [NV] = '{
    24'h4_1_00_00,                                // R1 status at reset
    24'h1_1_11_00, 24'h3_1_00_00,                 // R1 snapshot zero
    24'h1_2_01_00, 24'h2_2_56_00, 24'h2_2_34_00, 24'h2_2_12_00, // R2 preset
    24'h1_3_08_00,                                // R3 transfer
    24'h5_6_00_00,                                // R6 pulse while disabled
    24'h1_4_11_00, 24'h3_4_00_56, 24'h3_4_00_34, 24'h3_4_00_12, // R4
    24'h3_2_00_56,                                // R2 pointer wrap on read
    24'h1_6_41_00, 24'h5_6_00_00, 24'h6_6_00_00, 24'h5_6_00_00, // R6 enable
    24'h1_6_11_00, 24'h3_6_00_57, 24'h3_6_00_34, 24'h3_6_00_12,
    24'h4_7_00_20,                                // R7 direction up
    24'h1_7_01_00, 24'h2_7_FF_00, 24'h2_7_FF_00, 24'h2_7_FF_00, 24'h1_7_08_00,
    24'h5_7_00_00, 24'h4_7_00_22,                 // R7 wrap up -> carry
    24'h1_7_11_00, 24'h3_7_00_00,
    24'h6_7_00_00, 24'h4_7_00_03,                 // R7 wrap down -> borrow
    24'h1_5_04_00, 24'h4_5_00_00,                 // R5 clear flags
    24'h7_C_00_00, 24'h4_C_00_10,                 // R12 noise
    24'h1_C_06_00, 24'h4_C_00_00,                 // R12 clear error
    24'h1_5_02_00, 24'h1_5_11_00,                 // R5 clear counter
    24'h3_5_00_00, 24'h3_5_00_00, 24'h3_5_00_00,
    24'h4_5_00_00, 24'h1_5_01_00, 24'h4_5_00_00
  };

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every task starts and ends at a falling edge
  task automatic ctrl(logic [7:0] b);
    ctrlWe = 1'b1; wrData = b;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrByte(logic [7:0] b);
    dataWe = 1'b1; wrData = b;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  task automatic pulse(logic up, logic dn, logic ix, logic nz);
    cntUp = up; cntDn = dn; indexIn = ix; noiseIn = nz;
    @(negedge clk);
    cntUp = 1'b0; cntDn = 1'b0; indexIn = 1'b0; noiseIn = 1'b0;
  endtask

  task automatic rdByte(output logic [7:0] b);
    b = rdData;
    dataRe = 1'b1;
    @(negedge clk);
    dataRe = 1'b0;
  endtask

  task automatic setPreset(logic [23:0] v);
    ctrl(8'h01);
    wrByte(v[7:0]); wrByte(v[15:8]); wrByte(v[23:16]);
  endtask

  task automatic readSnap(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    ctrl(8'h01);
    rdByte(b0); rdByte(b1); rdByte(b2);
    v = {b2, b1, b0};
  endtask

  task automatic readCount(output logic [23:0] v);
    ctrl(8'h10);
    readSnap(v);
  endtask

  task automatic doVec(logic [23:0] vec);
    logic [3:0] op, req;
    logic [7:0] d, e, b;
    {op, req, d, e} = vec;
    case (op)
      4'h1: ctrl(d);
      4'h2: wrByte(d);
      4'h3: begin rdByte(b); chk($sformatf("R%0d data read", req), 24'(b), 24'(e)); end
      4'h4: chk($sformatf("R%0d status", req), 24'(statusByte), 24'(e));
      4'h5: pulse(1'b1, 1'b0, 1'b0, 1'b0);
      4'h6: pulse(1'b0, 1'b1, 1'b0, 1'b0);
      4'h7: pulse(1'b0, 1'b0, 1'b0, 1'b1);
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) doVec(VEC[i]);

    // R8 range-limit
    ctrl(8'h22);
    setPreset(24'h000005); ctrl(8'h08); ctrl(8'h04);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    readCount(v); chk("R8 hold at preset", v, 24'h000005);
    chk("R8 carry at limit", 24'(statusByte[1]), 24'h1);
    ctrl(8'h04); ctrl(8'h23); ctrl(8'h02);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    readCount(v); chk("R8 below limit counts", v, 24'h000001);
    pulse(1'b0, 1'b1, 1'b0, 1'b0); pulse(1'b0, 1'b1, 1'b0, 1'b0);
    readCount(v); chk("R8 hold at zero (bit0 ignored)", v, 24'h000000);
    chk("R8 borrow at zero", 24'(statusByte[1:0]), 24'h1);

    // R10 modulo-N
    ctrl(8'h26); setPreset(24'h000004); ctrl(8'h02); ctrl(8'h04);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    readCount(v); chk("R10 down from zero loads preset", v, 24'h000004);
    chk("R10 borrow", 24'(statusByte[1:0]), 24'h1);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    readCount(v); chk("R10 up at preset gives zero", v, 24'h000000);
    chk("R10 carry", 24'(statusByte[1:0]), 24'h3);

    // R9 non-recycle
    ctrl(8'h24); setPreset(24'hFFFFFF); ctrl(8'h08); ctrl(8'h04);
    pulse(1'b1, 1'b0, 1'b0, 1'b0); pulse(1'b1, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    readCount(v); chk("R9 frozen after wrap", v, 24'h000000);
    chk("R9 carry", 24'(statusByte[1:0]), 24'h2);
    ctrl(8'h08); pulse(1'b0, 1'b1, 1'b0, 1'b0);
    readCount(v); chk("R9 resumes after transfer", v, 24'hFFFFFE);

    // R11 index
    ctrl(8'h20); setPreset(24'h000100); ctrl(8'h02); ctrl(8'h61);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    readCount(v); chk("R11 index loads preset", v, 24'h000100);
    ctrl(8'h43); ctrl(8'h02);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    readCount(v); chk("R11 index blocked by io bit1", v, 24'h000000);

    // R6 simultaneous up and down
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    readCount(v); chk("R6 up+down no change", v, 24'h000000);

    // R13 count pulse during a control write
    cntUp = 1'b1; ctrl(8'h01); cntUp = 1'b0;
    readCount(v); chk("R13 pulse ignored in control cycle", v, 24'h000000);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    readCount(v); chk("R13 pulse counted otherwise", v, 24'h000001);

    // R5 transfer wins over clear
    setPreset(24'h000777); ctrl(8'h0A);
    readCount(v); chk("R5 transfer beats clear", v, 24'h000777);

    // R4 latch sees the value before a same-byte transfer
    setPreset(24'h000010); ctrl(8'h18);
    readSnap(v); chk("R4 snapshot before transfer", v, 24'h000777);
    readSnap(v); chk("R4 snapshot kept", v, 24'h000777);
    readCount(v); chk("R3 transfer in combined byte", v, 24'h000010);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule